// File: doc/BRIEF.md
# Minifloat Comparator

This block orders two 8-bit floating-point operands. Each operand has a sign bit, a biased exponent field and a fraction field, with the usual conventions for zero, denormal, normal, infinity and not-a-number encodings. The block returns four mutually exclusive flags: less-than, equal, greater-than and unordered.

The block does not decode the operands into values. It checks the signs first and then compares the seven magnitude bits as an unsigned integer. This works because, for nonnegative operands, the bit patterns already sort in value order across the denormal, normal and infinity ranges. Three corrections are applied on top of that compare: two zeros of opposite sign count as equal, a NaN on either side makes the result unordered, and the magnitude result is reversed when both operands are negative.

A parameter selects whether the flags go out through a single output register or straight from the combinational logic. A compare unit that feeds a pipeline stage would use the registered form.

Top module: `minifloat_cmp`

## Requirements
- R1: Bit 7 of an operand is the sign (1 = negative), bits 6:3 are the exponent field and bits 2:0 are the fraction field. For every pair of operands that are not NaN, the flags match the order of the real values those encodings represent.
- R2: An operand whose exponent field is 4'b1111 and whose fraction is nonzero is a NaN. If either operand is a NaN, only the unordered flag is set.
- R3: +0 (8'h00) and -0 (8'h80) compare equal in either order.
- R4: When the signs differ and the operands are not both zero, the operand with the sign bit set is the lesser one. This includes -0 against any positive nonzero value, and any negative nonzero value against +0.
- R5: When both signs are clear, the result follows the unsigned order of bits 6:0. This holds across the denormal, normal and infinity (exponent 4'b1111, fraction 0) encodings.
- R6: When both signs are set, the result is the reverse of the unsigned order of bits 6:0.
- R7: For every input pair, exactly one of the four flags is set.
- R8: Two identical non-NaN encodings, infinities included, compare equal.
- R9: With REG_OUT=1, a result appears on the outputs after the next rising clock edge and holds until the edge after that. While rstN is low, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| aIn | input | 8 | Left operand |
| bIn | input | 8 | Right operand |
| ltOut | output | 1 | aIn is less than bIn |
| eqOut | output | 1 | aIn equals bIn |
| gtOut | output | 1 | aIn is greater than bIn |
| unordOut | output | 1 | At least one operand is NaN |

## Verification
A fixed table of operand pairs covers the cases that plain unsigned compare would get wrong, and each pair singles out one case:
- the two zeros, in both orders;
- the largest denormal against the smallest normal;
- infinity against the largest normal;
- operands of mixed sign, including -0 against a tiny positive value;
- two negative operands, which the block must reverse;
- NaN in either position.

After the table, every one of the 65536 operand pairs is swept. Each result is checked against an ordering of real values decoded in the bench, and each result is also checked to carry exactly one flag. Directed steps then confirm that the flags are cleared during reset and that a new result appears one clock edge after the operands change.

// File: rtl/mfcmp_pkg.sv
package mfcmp_pkg;

  // Operand classes
  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_DENORM,
    CLS_NORMAL,
    CLS_INF,
    CLS_NAN
  } fclass_e;

  // Strobes that the control sends to the datapath
  typedef struct packed {
    logic forceUnord;   // a NaN is present
    logic forceEq;      // both operands are zeros
    logic signSplit;    // signs differ and not both zero
    logic negA;         // sign of the left operand
    logic bothNeg;      // reverse the magnitude order
  } cmpStrobe_t;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
    logic unord;
  } cmpFlags_t;

endpackage

// File: rtl/mfcmp_classify.sv
module mfcmp_classify
  import mfcmp_pkg::*;
#(
  parameter int EXP_W  = 4,
  parameter int FRAC_W = 3
) (
  input  logic [EXP_W+FRAC_W:0] opIn,
  output fclass_e               clsOut,
  output logic                  signOut
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic              expAllOnes;
  logic              expAllZero;
  logic              fracZero;

  assign signOut    = opIn[W-1];
  assign expField   = opIn[W-2:FRAC_W];
  assign fracField  = opIn[FRAC_W-1:0];
  assign expAllOnes = &expField;
  assign expAllZero = ~|expField;
  assign fracZero   = ~|fracField;

  always_comb begin
    if (expAllOnes)      clsOut = fracZero ? CLS_INF : CLS_NAN;
    else if (expAllZero) clsOut = fracZero ? CLS_ZERO : CLS_DENORM;
    else                 clsOut = CLS_NORMAL;
  end
endmodule

// File: rtl/mfcmp_ctrl.sv
module mfcmp_ctrl
  import mfcmp_pkg::*;
(
  input  fclass_e    clsA,
  input  fclass_e    clsB,
  input  logic       signA,
  input  logic       signB,
  output cmpStrobe_t strobe
);
  logic anyNan;
  logic bothZero;

  assign anyNan   = (clsA == CLS_NAN) || (clsB == CLS_NAN);
  assign bothZero = (clsA == CLS_ZERO) && (clsB == CLS_ZERO);

  always_comb begin
    strobe            = '0;
    strobe.forceUnord = anyNan;
    strobe.forceEq    = !anyNan && bothZero;
    strobe.signSplit  = !anyNan && !bothZero && (signA != signB);
    strobe.negA       = signA;
    strobe.bothNeg    = signA && signB;
  end
endmodule

// File: rtl/mfcmp_datapath.sv
module mfcmp_datapath
  import mfcmp_pkg::*;
#(
  parameter int EXP_W  = 4,
  parameter int FRAC_W = 3
) (
  input  logic [EXP_W+FRAC_W:0] aIn,
  input  logic [EXP_W+FRAC_W:0] bIn,
  input  cmpStrobe_t            strobe,
  output cmpFlags_t             flagsOut
);
  localparam int MAG_W = EXP_W + FRAC_W;

  logic [MAG_W-1:0] magA;
  logic [MAG_W-1:0] magB;
  logic             magLt;
  logic             magEq;

  assign magA  = aIn[MAG_W-1:0];
  assign magB  = bIn[MAG_W-1:0];
  assign magLt = magA < magB;
  assign magEq = magA == magB;

  always_comb begin
    flagsOut = '0;
    if (strobe.forceUnord) begin
      flagsOut.unord = 1'b1;
    end else if (strobe.forceEq) begin
      flagsOut.eq = 1'b1;
    end else if (strobe.signSplit) begin
      flagsOut.lt = strobe.negA;
      flagsOut.gt = !strobe.negA;
    end else if (magEq) begin
      flagsOut.eq = 1'b1;
    end else begin
      flagsOut.lt = magLt ^ strobe.bothNeg;
      flagsOut.gt = !(magLt ^ strobe.bothNeg);
    end
  end
endmodule

// File: rtl/minifloat_cmp.sv
module minifloat_cmp
  import mfcmp_pkg::*;
#(
  parameter int EXP_W   = 4,
  parameter int FRAC_W  = 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [EXP_W+FRAC_W:0] aIn,
  input  logic [EXP_W+FRAC_W:0] bIn,
  output logic                  ltOut,
  output logic                  eqOut,
  output logic                  gtOut,
  output logic                  unordOut
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic [W-1:0] opArr  [2];
  fclass_e      clsArr [2];
  logic         sgnArr [2];
  cmpStrobe_t   strobe;
  cmpFlags_t    flagsComb;
  cmpFlags_t    flagsOut;

  assign opArr[0] = aIn;
  assign opArr[1] = bIn;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    mfcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .opIn   (opArr[i]),
      .clsOut (clsArr[i]),
      .signOut(sgnArr[i])
    );
  end

  mfcmp_ctrl u_ctrl (
    .clsA  (clsArr[0]),
    .clsB  (clsArr[1]),
    .signA (sgnArr[0]),
    .signB (sgnArr[1]),
    .strobe(strobe)
  );

  mfcmp_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .aIn     (aIn),
    .bIn     (bIn),
    .strobe  (strobe),
    .flagsOut(flagsComb)
  );

  if (REG_OUT) begin : g_reg
    cmpFlags_t flagsQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagsQ <= '0;
      else       flagsQ <= flagsComb;
    end
    assign flagsOut = flagsQ;

    // R9: the outputs carry the previous cycle's combinational result
    a_r9_reg_follow: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (flagsOut == $past(flagsComb)));
  end else begin : g_comb
    assign flagsOut = flagsComb;
  end

  assign ltOut    = flagsOut.lt;
  assign eqOut    = flagsOut.eq;
  assign gtOut    = flagsOut.gt;
  assign unordOut = flagsOut.unord;

  // R7: exactly one flag
  a_r7_one_flag: assert property (@(posedge clk) disable iff (!rstN)
    $countones(flagsComb) == 1);

  // R2: a NaN class on either side gives unordered
  a_r2_nan_unord: assert property (@(posedge clk) disable iff (!rstN)
    (clsArr[0] == CLS_NAN || clsArr[1] == CLS_NAN) |-> flagsComb.unord);

  // R3: two zeros are equal
  a_r3_zero_eq: assert property (@(posedge clk) disable iff (!rstN)
    (clsArr[0] == CLS_ZERO && clsArr[1] == CLS_ZERO) |-> flagsComb.eq);

  // R4: with mixed signs the negative operand is the lesser
  a_r4_sign_split: assert property (@(posedge clk) disable iff (!rstN)
    (clsArr[0] != CLS_NAN && clsArr[1] != CLS_NAN && aIn[W-1] != bIn[W-1]
     && !(clsArr[0] == CLS_ZERO && clsArr[1] == CLS_ZERO))
    |-> (aIn[W-1] ? flagsComb.lt : flagsComb.gt));

  // R8: identical non-NaN encodings are equal
  a_r8_same_eq: assert property (@(posedge clk) disable iff (!rstN)
    (aIn == bIn && clsArr[0] != CLS_NAN) |-> flagsComb.eq);
endmodule

// File: tb/minifloat_cmp_tb.sv
module minifloat_cmp_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] aIn = '0;
  logic [7:0] bIn = '0;
  logic       ltOut, eqOut, gtOut, unordOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  minifloat_cmp u_dut (
    .clk(clk), .rstN(rstN), .aIn(aIn), .bIn(bIn),
    .ltOut(ltOut), .eqOut(eqOut), .gtOut(gtOut), .unordOut(unordOut)
  );

  // Expected flag code {lt,eq,gt,unord}
  localparam logic [3:0] LT = 4'b1000, EQ = 4'b0100, GT = 4'b0010, UN = 4'b0001;
  localparam int NV = 20;
  // entry: {a, b, expected, requirement number}
  localparam logic [23:0] VEC [NV] = '{
    {8'h00, 8'h80, EQ, 4'd3},  // R3 +0 vs -0
    {8'h80, 8'h00, EQ, 4'd3},  // R3 -0 vs +0
    {8'h78, 8'h77, GT, 4'd5},  // R5 inf above max normal
    {8'h07, 8'h08, LT, 4'd5},  // R5 max denorm below min normal
    {8'h01, 8'h00, GT, 4'd5},  // R5 tiny denorm above zero
    {8'h38, 8'h39, LT, 4'd5},  // R5 one vs next above
    {8'h79, 8'h00, UN, 4'd2},  // R2 NaN left
    {8'h00, 8'h7F, UN, 4'd2},  // R2 NaN right
    {8'hF9, 8'hF9, UN, 4'd2},  // R2 same NaN both sides
    {8'hF8, 8'h78, LT, 4'd4},  // R4 -inf vs +inf
    {8'h81, 8'h01, LT, 4'd4},  // R4
    {8'h01, 8'h81, GT, 4'd4},  // R4
    {8'h80, 8'h01, LT, 4'd4},  // R4 -0 vs tiny positive
    {8'h81, 8'h00, LT, 4'd4},  // R4 tiny negative vs +0
    {8'hB8, 8'hB0, LT, 4'd6},  // R6 -1 vs -0.5
    {8'hF8, 8'hF7, LT, 4'd6},  // R6 -inf vs -max
    {8'h81, 8'h82, GT, 4'd6},  // R6
    {8'h5A, 8'h5A, EQ, 4'd8},  // R8
    {8'hC3, 8'hC3, EQ, 4'd8},  // R8
    {8'hF8, 8'hF8, EQ, 4'd8}   // R8 -inf equals -inf
  };

  function automatic logic [3:0] flagsNow();
    return {ltOut, eqOut, gtOut, unordOut};
  endfunction

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: flags %b expected %b (a=%h b=%h)", req, got, exp, aIn, bIn);
    end
  endtask

  // Reference value decoding (R1)
  function automatic real fval(input logic [7:0] x);
    int  e = int'(x[6:3]);
    int  f = int'(x[2:0]);
    real m;
    if (e == 15)     m = 1.0e30;
    else if (e == 0) m = (real'(f) / 8.0) * (2.0 ** (-6));
    else             m = (real'(8 + f) / 8.0) * (2.0 ** (e - 7));
    return x[7] ? -m : m;
  endfunction

  function automatic logic [3:0] refFlags(input logic [7:0] a, input logic [7:0] b);
    real va, vb;
    if ((a[6:3] == 4'hF && a[2:0] != 0) || (b[6:3] == 4'hF && b[2:0] != 0)) return UN;
    va = fval(a);
    vb = fval(b);
    if (va < vb) return LT;
    if (va > vb) return GT;
    return EQ;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R9: outputs clear during reset
    aIn = 8'h01; bIn = 8'h00;
    repeat (3) @(negedge clk);
    check("R9 reset", flagsNow(), 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 first result", flagsNow(), GT);

    // Table of vectors: drive at a negedge, read one edge later
    for (int i = 0; i < NV; i++) begin
      aIn = VEC[i][23:16];
      bIn = VEC[i][15:8];
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i), flagsNow(), VEC[i][7:4]);
    end

    // R9: latency, old result holds until the edge
    aIn = 8'h01; bIn = 8'h00;
    @(negedge clk);
    aIn = 8'h00; bIn = 8'h01;
    #1;
    check("R9 hold before edge", flagsNow(), GT);
    @(negedge clk);
    check("R9 update after edge", flagsNow(), LT);

    // R1 and R7: every operand pair against the decoded reference
    for (int p = 0; p < 65536; p++) begin
      aIn = p[15:8];
      bIn = p[7:0];
      @(negedge clk);
      check("R1 sweep", flagsNow(), refFlags(p[15:8], p[7:0]));
      check("R7 one flag", 4'($countones(flagsNow())), 4'd1);
    end

    // R9: asserting reset again clears the flags
    rstN = 1'b0;
    #1;
    check("R9 reset again", flagsNow(), 4'b0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule